// File: doc/BRIEF.md
# Hashed Inverted Page Table Lookup Engine

This block translates a (process ID, virtual page number) pair into a physical frame index. The translation table is indexed by physical frame and holds one entry per frame. All resident processes share that one table. Each entry records the owning process, the virtual page held in the frame, and a link to the next entry in its collision chain. The virtual page number is folded into an index into a separate anchor table. An anchor holds the head of a chain, or the nil code when the chain is empty. The engine walks the chain one entry per cycle. When an entry matches, the index of that entry is the translation result.

A small fully associative translation cache sits in front of the walk and answers repeated lookups in one cycle. Cache entries are tagged with the process ID, so a context switch needs no flush. Any write to either table clears the cache, so that a stale translation is never served. The walk gives up with a fault if it visits as many entries as there are frames without reaching nil. This stops a corrupted cyclic chain from hanging the engine.

Table contents are loaded through two write ports, one for entries and one for anchors. Lookups use a valid/ready request and a single-cycle response pulse.

Top module: `ipt_lookup`

## Requirements
- R1: After reset, req_ready_o is 1 and rsp_valid_o is 0. Every entry is invalid and every anchor holds nil, so any lookup misses.
- R2: The anchor index is the XOR of bits [7:0] and bits [15:8] of the virtual page number, reduced to its low 6 bits. For example, 0x1234 selects anchor 0x26 and 0xFF00 selects anchor 0x3F.
- R3: An entry matches when its valid bit is 1 and both its process ID and its virtual page equal the request. The walk follows the next-pointers from the anchor and stops at the first matching entry. The result has rsp_hit_o = 1, and rsp_frame_o is the index of the matching entry.
- R4: A pointer of 7 bits with bit 6 set is nil, and bits [5:0] of any other pointer give the frame. A walk that reaches nil responds with rsp_hit_o = 0 and rsp_loop_o = 0.
- R5: A walk that passes n non-matching entries responds n+2 cycles after the request is driven. A cache hit responds 1 cycle after the request is driven.
- R6: If 64 entries have been passed with no match and no nil, the response carries rsp_loop_o = 1 and rsp_hit_o = 0, 66 cycles after the request.
- R7: A walk hit fills the translation cache. A later lookup of the same pair is answered from the cache, with rsp_cached_o = 1.
- R8: A cached translation is used only when the process ID matches. The same page under another process ID performs a full walk.
- R9: The cache holds 4 entries and fills them in round-robin order. The fifth distinct fill evicts the first one.
- R10: Any write to the entry table or the anchor table clears every cached translation.
- R11: While a walk is in progress, req_ready_o is 0 and requests are ignored.
- R12: Each accepted request produces exactly one rsp_valid_o pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request |
| req_pid_i | input | 4 | Requesting process ID |
| req_vpn_i | input | 16 | Virtual page number |
| req_ready_o | output | 1 | Engine idle, request accepted |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_hit_o | output | 1 | Translation found |
| rsp_loop_o | output | 1 | Walk limit exceeded |
| rsp_cached_o | output | 1 | Answered from translation cache |
| rsp_frame_o | output | 6 | Physical frame index |
| ent_we_i | input | 1 | Entry table write strobe |
| ent_idx_i | input | 6 | Entry (frame) to write |
| ent_valid_i | input | 1 | Entry valid bit |
| ent_pid_i | input | 4 | Entry process ID |
| ent_vpn_i | input | 16 | Entry virtual page |
| ent_next_i | input | 7 | Entry next-pointer (bit 6 = nil) |
| anc_we_i | input | 1 | Anchor table write strobe |
| anc_idx_i | input | 6 | Anchor to write |
| anc_ptr_i | input | 7 | Chain head pointer (bit 6 = nil) |

## Verification
A cache hit is due one cycle after the request. A walk result is due n+2 cycles after the request, where n is the number of non-matching entries passed before a match or nil. A cyclic chain reports its fault at 66 cycles. For every lookup the bench predicts both the result and this latency from its own model of the tables and the cache. It counts cycles at falling edges from the request until the pulse appears and compares the count with the prediction. It then checks that the pulse is gone on the following falling edge.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
  parameter int FRAMES = 64;
  parameter int ANCH   = 64;
  parameter int PID_W  = 4;
  parameter int VPN_W  = 16;
  parameter int TLB_N  = 4;

  localparam int FIDX_W = $clog2(FRAMES);
  localparam int PTR_W  = FIDX_W + 1;
  localparam int AIDX_W = $clog2(ANCH);
  localparam int CNT_W  = $clog2(FRAMES + 1);
  localparam int HALF_W = VPN_W / 2;
  localparam logic [PTR_W-1:0] NIL = {1'b1, {FIDX_W{1'b0}}};

  typedef struct packed {
    logic             valid;
    logic [PID_W-1:0] pid;
    logic [VPN_W-1:0] vpn;
    logic [PTR_W-1:0] next;
  } ipt_ent_t;

  function automatic logic [AIDX_W-1:0] vpn_hash(input logic [VPN_W-1:0] vpn);
    logic [HALF_W-1:0] h;
    h = vpn[HALF_W-1:0] ^ vpn[VPN_W-1:HALF_W];
    return h[AIDX_W-1:0];
  endfunction
endpackage

// File: rtl/ipt_store.sv
module ipt_store
  import ipt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ent_we_i,
  input  logic [FIDX_W-1:0] ent_widx_i,
  input  ipt_ent_t          ent_wdata_i,
  input  logic              anc_we_i,
  input  logic [AIDX_W-1:0] anc_widx_i,
  input  logic [PTR_W-1:0]  anc_wdata_i,
  input  logic [FIDX_W-1:0] ent_ridx_i,
  output ipt_ent_t          ent_rdata_o,
  input  logic [AIDX_W-1:0] anc_ridx_i,
  output logic [PTR_W-1:0]  anc_rdata_o
);
  ipt_ent_t          ent_q [FRAMES];
  logic [PTR_W-1:0]  anc_q [ANCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < FRAMES; i++) ent_q[i] <= '0;
    end else if (ent_we_i) begin
      ent_q[ent_widx_i] <= ent_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ANCH; i++) anc_q[i] <= NIL;
    end else if (anc_we_i) begin
      anc_q[anc_widx_i] <= anc_wdata_i;
    end
  end

  assign ent_rdata_o = ent_q[ent_ridx_i];
  assign anc_rdata_o = anc_q[anc_ridx_i];
endmodule

// File: rtl/ipt_xlat_cache.sv
module ipt_xlat_cache
  import ipt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [PID_W-1:0]  pid_i,
  input  logic [VPN_W-1:0]  vpn_i,
  output logic              hit_o,
  output logic [FIDX_W-1:0] frame_o,
  input  logic              fill_i,
  input  logic [PID_W-1:0]  fill_pid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [FIDX_W-1:0] fill_frame_i
);
  localparam int RR_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;

  logic [TLB_N-1:0]  val_q;
  logic [PID_W-1:0]  pid_q [TLB_N];
  logic [VPN_W-1:0]  vpn_q [TLB_N];
  logic [FIDX_W-1:0] frm_q [TLB_N];
  logic [RR_W-1:0]   rr_q;
  logic [TLB_N-1:0]  hit_vec;

  for (genvar g = 0; g < TLB_N; g++) begin : g_cmp
    assign hit_vec[g] = val_q[g] && (pid_q[g] == pid_i) && (vpn_q[g] == vpn_i);
  end

  always_comb begin
    frame_o = '0;
    for (int i = 0; i < TLB_N; i++) if (hit_vec[i]) frame_o = frame_o | frm_q[i];
  end
  assign hit_o = |hit_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '0;
      rr_q  <= '0;
      for (int i = 0; i < TLB_N; i++) begin
        pid_q[i] <= '0;
        vpn_q[i] <= '0;
        frm_q[i] <= '0;
      end
    end else if (flush_i) begin
      val_q <= '0;
      rr_q  <= '0;
    end else if (fill_i) begin
      val_q[rr_q] <= 1'b1;
      pid_q[rr_q] <= fill_pid_i;
      vpn_q[rr_q] <= fill_vpn_i;
      frm_q[rr_q] <= fill_frame_i;
      rr_q        <= (rr_q == RR_W'(TLB_N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  // fills happen only after a cache miss, so tags stay unique
  p_tag_unique_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  p_flush_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o);
endmodule

// File: rtl/ipt_walker.sv
module ipt_walker
  import ipt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [PID_W-1:0]  req_pid_i,
  input  logic [VPN_W-1:0]  req_vpn_i,
  output logic              req_ready_o,
  input  logic              cache_hit_i,
  input  logic [FIDX_W-1:0] cache_frame_i,
  output logic [AIDX_W-1:0] anc_ridx_o,
  input  logic [PTR_W-1:0]  anc_i,
  output logic [FIDX_W-1:0] ent_ridx_o,
  input  ipt_ent_t          ent_i,
  output logic              fill_o,
  output logic [PID_W-1:0]  fill_pid_o,
  output logic [VPN_W-1:0]  fill_vpn_o,
  output logic [FIDX_W-1:0] fill_frame_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_loop_o,
  output logic              rsp_cached_o,
  output logic [FIDX_W-1:0] rsp_frame_o
);
  typedef enum logic {W_IDLE, W_WALK} wstate_e;
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(FRAMES);

  wstate_e           st_q;
  logic [PTR_W-1:0]  cur_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PID_W-1:0]  pid_q;
  logic [VPN_W-1:0]  vpn_q;
  logic              accept, cur_nil, at_limit, match;

  assign req_ready_o = (st_q == W_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign anc_ridx_o  = vpn_hash(req_vpn_i);
  assign ent_ridx_o  = cur_q[FIDX_W-1:0];
  assign cur_nil     = cur_q[PTR_W-1];
  assign at_limit    = (cnt_q == LIMIT);
  assign match       = ent_i.valid && (ent_i.pid == pid_q) && (ent_i.vpn == vpn_q);

  assign fill_o       = (st_q == W_WALK) && !cur_nil && !at_limit && match;
  assign fill_pid_o   = pid_q;
  assign fill_vpn_o   = vpn_q;
  assign fill_frame_o = cur_q[FIDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= W_IDLE;
      cur_q        <= NIL;
      cnt_q        <= '0;
      pid_q        <= '0;
      vpn_q        <= '0;
      rsp_valid_o  <= 1'b0;
      rsp_hit_o    <= 1'b0;
      rsp_loop_o   <= 1'b0;
      rsp_cached_o <= 1'b0;
      rsp_frame_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (st_q)
        W_IDLE: if (accept) begin
          if (cache_hit_i) begin
            rsp_valid_o  <= 1'b1;
            rsp_hit_o    <= 1'b1;
            rsp_loop_o   <= 1'b0;
            rsp_cached_o <= 1'b1;
            rsp_frame_o  <= cache_frame_i;
          end else begin
            st_q  <= W_WALK;
            cur_q <= anc_i;
            cnt_q <= '0;
            pid_q <= req_pid_i;
            vpn_q <= req_vpn_i;
          end
        end
        W_WALK: begin
          if (cur_nil || at_limit || match) begin
            st_q         <= W_IDLE;
            rsp_valid_o  <= 1'b1;
            rsp_cached_o <= 1'b0;
            rsp_hit_o    <= !cur_nil && !at_limit;
            rsp_loop_o   <= !cur_nil && at_limit;
            rsp_frame_o  <= (!cur_nil && !at_limit) ? cur_q[FIDX_W-1:0] : '0;
          end else begin
            cur_q <= ent_i.next;
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= W_IDLE;
      endcase
    end
  end

  p_hit_not_loop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !(rsp_hit_o && rsp_loop_o));
  p_walk_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == W_WALK) |-> (cnt_q <= LIMIT));
  p_busy_from_req_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_ready_o) |-> $past(req_valid_i));
  p_cached_when_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_cached_o) |-> $past(req_valid_i && req_ready_o));
  p_busy_no_rsp_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && $past(!req_ready_o)) |-> !rsp_valid_o);
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup
  import ipt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [PID_W-1:0]  req_pid_i,
  input  logic [VPN_W-1:0]  req_vpn_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_loop_o,
  output logic              rsp_cached_o,
  output logic [FIDX_W-1:0] rsp_frame_o,
  input  logic              ent_we_i,
  input  logic [FIDX_W-1:0] ent_idx_i,
  input  logic              ent_valid_i,
  input  logic [PID_W-1:0]  ent_pid_i,
  input  logic [VPN_W-1:0]  ent_vpn_i,
  input  logic [PTR_W-1:0]  ent_next_i,
  input  logic              anc_we_i,
  input  logic [AIDX_W-1:0] anc_idx_i,
  input  logic [PTR_W-1:0]  anc_ptr_i
);
  ipt_ent_t          wdata, ent_rd;
  logic [FIDX_W-1:0] ent_ridx;
  logic [AIDX_W-1:0] anc_ridx;
  logic [PTR_W-1:0]  anc_rd;
  logic              c_hit, fill;
  logic [FIDX_W-1:0] c_frame, fill_frame;
  logic [PID_W-1:0]  fill_pid;
  logic [VPN_W-1:0]  fill_vpn;

  assign wdata = '{valid: ent_valid_i, pid: ent_pid_i, vpn: ent_vpn_i, next: ent_next_i};

  ipt_store i_store (
    .clk_i, .rst_ni,
    .ent_we_i, .ent_widx_i(ent_idx_i), .ent_wdata_i(wdata),
    .anc_we_i, .anc_widx_i(anc_idx_i), .anc_wdata_i(anc_ptr_i),
    .ent_ridx_i(ent_ridx), .ent_rdata_o(ent_rd),
    .anc_ridx_i(anc_ridx), .anc_rdata_o(anc_rd)
  );

  ipt_xlat_cache i_cache (
    .clk_i, .rst_ni,
    .flush_i(ent_we_i || anc_we_i),
    .pid_i(req_pid_i), .vpn_i(req_vpn_i),
    .hit_o(c_hit), .frame_o(c_frame),
    .fill_i(fill), .fill_pid_i(fill_pid), .fill_vpn_i(fill_vpn), .fill_frame_i(fill_frame)
  );

  ipt_walker i_walker (
    .clk_i, .rst_ni,
    .req_valid_i, .req_pid_i, .req_vpn_i, .req_ready_o,
    .cache_hit_i(c_hit), .cache_frame_i(c_frame),
    .anc_ridx_o(anc_ridx), .anc_i(anc_rd),
    .ent_ridx_o(ent_ridx), .ent_i(ent_rd),
    .fill_o(fill), .fill_pid_o(fill_pid), .fill_vpn_o(fill_vpn), .fill_frame_o(fill_frame),
    .rsp_valid_o, .rsp_hit_o, .rsp_loop_o, .rsp_cached_o, .rsp_frame_o
  );

  p_hit_result_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_hit_o && !rsp_cached_o) |-> $past(fill));
endmodule

// File: tb/test_ipt_lookup.sv
`timescale 1ns/1ps
module test_ipt_lookup;
  localparam time CLK_P = 5ns;
  localparam logic [6:0] NIL = 7'h40;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [3:0]  req_pid = '0;
  logic [15:0] req_vpn = '0;
  logic        rsp_valid, rsp_hit, rsp_loop, rsp_cached;
  logic [5:0]  rsp_frame;
  logic        ent_we = 1'b0, ent_valid = 1'b0, anc_we = 1'b0;
  logic [5:0]  ent_idx = '0, anc_idx = '0;
  logic [3:0]  ent_pid = '0;
  logic [15:0] ent_vpn = '0;
  logic [6:0]  ent_next = '0, anc_ptr = '0;

  int total = 0, bad = 0;

  // model state
  bit         m_val [64];
  logic [3:0] m_pid [64];
  logic [15:0] m_vpn [64];
  logic [6:0] m_next [64];
  logic [6:0] m_anc [64];
  bit         c_val [4];
  logic [3:0] c_pid [4];
  logic [15:0] c_vpn [4];
  int         c_frm [4];
  int         c_rr;

  always #(CLK_P/2) clk = ~clk;

  ipt_lookup i_ipt_lookup (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_pid_i(req_pid), .req_vpn_i(req_vpn), .req_ready_o(req_ready),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_loop_o(rsp_loop),
    .rsp_cached_o(rsp_cached), .rsp_frame_o(rsp_frame),
    .ent_we_i(ent_we), .ent_idx_i(ent_idx), .ent_valid_i(ent_valid), .ent_pid_i(ent_pid),
    .ent_vpn_i(ent_vpn), .ent_next_i(ent_next),
    .anc_we_i(anc_we), .anc_idx_i(anc_idx), .anc_ptr_i(anc_ptr)
  );

  function automatic logic [5:0] hsh(input logic [15:0] v);
    logic [7:0] h;
    h = v[7:0] ^ v[15:8];
    return h[5:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_flush();
    for (int i = 0; i < 4; i++) c_val[i] = 0;
    c_rr = 0;
  endtask

  task automatic model(input logic [3:0] p, input logic [15:0] v,
                       output bit eh, output bit el, output bit ec, output int ef, output int lat);
    logic [6:0] ptr;
    int steps;
    eh = 0; el = 0; ec = 0; ef = 0; lat = 0;
    for (int i = 0; i < 4; i++)
      if (c_val[i] && c_pid[i] == p && c_vpn[i] == v) begin
        eh = 1; ec = 1; ef = c_frm[i]; lat = 1;
      end
    if (ec) return;
    ptr = m_anc[hsh(v)];
    steps = 0;
    while (1) begin
      if (ptr[6]) break;
      if (steps == 64) begin el = 1; break; end
      if (m_val[ptr[5:0]] && m_pid[ptr[5:0]] == p && m_vpn[ptr[5:0]] == v) begin
        eh = 1; ef = int'(ptr[5:0]);
        c_val[c_rr] = 1; c_pid[c_rr] = p; c_vpn[c_rr] = v; c_frm[c_rr] = ef;
        c_rr = (c_rr + 1) % 4;
        break;
      end
      ptr = m_next[ptr[5:0]];
      steps++;
    end
    lat = steps + 2;
  endtask

  task automatic wr_ent(input int idx, input bit v, input logic [3:0] p,
                        input logic [15:0] vp, input logic [6:0] nx);
    @(negedge clk);
    ent_we = 1; ent_idx = 6'(idx); ent_valid = v; ent_pid = p; ent_vpn = vp; ent_next = nx;
    @(negedge clk);
    ent_we = 0;
    m_val[idx] = v; m_pid[idx] = p; m_vpn[idx] = vp; m_next[idx] = nx;
    model_flush();
  endtask

  task automatic wr_anc(input int idx, input logic [6:0] ptr);
    @(negedge clk);
    anc_we = 1; anc_idx = 6'(idx); anc_ptr = ptr;
    @(negedge clk);
    anc_we = 0;
    m_anc[idx] = ptr;
    model_flush();
  endtask

  // busy_poke: drive a competing request during the first cycles of a walk (R11)
  task automatic lookup(input logic [3:0] p, input logic [15:0] v, input string req,
                        input bit busy_poke = 0);
    bit eh, el, ec;
    int ef, elat, lat;
    model(p, v, eh, el, ec, ef, elat);
    @(negedge clk);
    chk(req_ready == 1'b1, req, "ready before request", int'(req_ready), 1);
    req_valid = 1; req_pid = p; req_vpn = v;
    @(negedge clk);
    lat = 1;
    if (busy_poke) begin
      for (int k = 0; k < 5 && !rsp_valid; k++) begin
        chk(req_ready == 1'b0, "R11", "ready during walk", int'(req_ready), 0);
        req_pid = ~p; req_vpn = ~v;
        @(negedge clk);
        lat++;
      end
    end
    req_valid = 0;
    while (!rsp_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == elat, req, "latency", lat, elat);
    chk(rsp_hit == eh, req, "hit", int'(rsp_hit), int'(eh));
    chk(rsp_loop == el, req, "loop", int'(rsp_loop), int'(el));
    chk(rsp_cached == ec, req, "cached", int'(rsp_cached), int'(ec));
    if (eh) chk(int'(rsp_frame) == ef, req, "frame", int'(rsp_frame), ef);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R12", "pulse width", int'(rsp_valid), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0] rp [6];
    logic [15:0] rv [6];
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin
      m_val[i] = 0; m_pid[i] = '0; m_vpn[i] = '0; m_next[i] = '0; m_anc[i] = NIL;
    end
    model_flush();
    for (int i = 0; i < 6; i++) begin rp[i] = '0; rv[i] = '0; end

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "no response after reset", int'(rsp_valid), 0);
    lookup(4'd2, 16'hBEEF, "R1");
    lookup(4'd0, 16'h0000, "R4");

    // R2: 0x1234 -> anchor 0x26
    wr_ent(5, 1, 4'd3, 16'h1234, NIL);
    wr_anc(6'h26, 7'd5);
    lookup(4'd3, 16'h1234, "R2");
    lookup(4'd3, 16'h1234, "R7");
    lookup(4'd4, 16'h1234, "R8");
    lookup(4'd3, 16'h1234, "R7");
    wr_ent(40, 0, 4'd0, 16'h0, NIL);
    lookup(4'd3, 16'h1234, "R10");

    // R3/R5: two pages sharing anchor 0x3F, chain 8 -> 7
    wr_ent(7, 1, 4'd1, 16'hFF00, NIL);
    wr_ent(8, 1, 4'd1, 16'h0FF0, 7'd7);
    wr_anc(6'h3F, 7'd8);
    lookup(4'd1, 16'hFF00, "R3");
    lookup(4'd1, 16'h0FF0, "R5");
    lookup(4'd1, 16'h33CC, "R4");
    lookup(4'd2, 16'hFF00, "R3");

    // R9: five distinct fills, then the first one must walk again
    lookup(4'd3, 16'h1234, "R9");
    lookup(4'd1, 16'hFF00, "R9");
    lookup(4'd1, 16'h0FF0, "R9");
    wr_ent(9, 1, 4'd6, 16'h0102, NIL);
    wr_anc(6'h03, 7'd9);
    wr_ent(10, 1, 4'd7, 16'h0405, NIL);
    wr_anc(6'h01, 7'd10);
    lookup(4'd3, 16'h1234, "R9");
    lookup(4'd1, 16'hFF00, "R9");
    lookup(4'd1, 16'h0FF0, "R9");
    lookup(4'd6, 16'h0102, "R9");
    lookup(4'd7, 16'h0405, "R9");
    lookup(4'd3, 16'h1234, "R9");
    chk(rsp_cached == 1'b0, "R9", "evicted entry walked", int'(rsp_cached), 0);

    // random table with long collision chains
    for (int a = 0; a < 64; a++) wr_anc(a, NIL);
    for (int f = 0; f < 64; f++) begin
      if ($urandom % 4 != 0) begin
        logic [3:0] p;
        logic [15:0] v;
        logic [7:0] u;
        p = 4'($urandom % 16);
        u = 8'($urandom);
        if ($urandom % 2 != 0) v = {u, u ^ 8'($urandom % 4)};
        else v = 16'($urandom);
        wr_ent(f, 1, p, v, m_anc[hsh(v)]);
        wr_anc(hsh(v), {1'b0, 6'(f)});
      end else begin
        wr_ent(f, 0, 4'd0, 16'h0, NIL);
      end
    end
    for (int n = 0; n < 400; n++) begin
      logic [3:0] p;
      logic [15:0] v;
      int sel, f;
      sel = int'($urandom % 100);
      f = int'($urandom % 64);
      if (sel < 30) begin
        p = rp[$urandom % 6]; v = rv[$urandom % 6];
        if ($urandom % 2 != 0) begin
          int k = int'($urandom % 6);
          p = rp[k]; v = rv[k];
        end
      end else if (sel < 75 && m_val[f]) begin
        p = m_pid[f]; v = m_vpn[f];
      end else if (sel < 85 && m_val[f]) begin
        p = 4'($urandom % 16); v = m_vpn[f];
      end else begin
        p = 4'($urandom % 16); v = 16'($urandom);
      end
      lookup(p, v, "R3");
      rp[n % 6] = p; rv[n % 6] = v;
    end

    // R6/R11: cyclic chain 20 -> 21 -> 20 on anchor 0
    wr_ent(20, 1, 4'd1, 16'h0202, 7'd21);
    wr_ent(21, 1, 4'd1, 16'h0303, 7'd20);
    wr_anc(0, 7'd20);
    lookup(4'd1, 16'h0101, "R6", 1'b1);
    chk(rsp_loop == 1'b1, "R6", "loop fault flag", int'(rsp_loop), 1);
    repeat (3) begin
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R12", "no extra response", int'(rsp_valid), 0);
    end
    lookup(4'd1, 16'h0303, "R3");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule